// File: doc/BRIEF.md
# Stream Core Run/Halt Controller

This block is the control and status front end for one direction of a programmable bit-manipulation stream core. Software programs it through a small 32-bit register port. Three words are visible: a control word, a tail-bit count and a status word. From the control word the block runs a four-state sequencer (idle, run, wait, pause). The sequencer tells the datapath when to execute, when to fetch its first instruction and when to request input data.

While the core halts, the block can wait for the datapath to finish its write-back, or it can abandon that write-back at once. The block also counts the bytes of each frame up to the end-of-frame marker. It holds the first captured count for software to read. If a further frame ends before software clears the trace, it raises a sticky overload flag.

Writes to the FIFO-reset bit and the trace-clear bit act as one-shot triggers and are never stored. An asynchronous active-low reset is released to the logic through a synchroniser.

Top module: `scx_run_ctrl`

## Requirements
- R1: After reset the control word (address 0) reads 0x00000004, so only the halt bit is set. The status word (address 2) reads 0x00000001 plus the FIFO-empty bit. The tail word (address 1) reads 0.
- R2: Control word fields: bit 0 enable, bit 1 pause, bit 2 halt, bit 3 EOF mode, bit 4 condition mode, bit 5 fetch mode, bit 6 halt mode, bit 7 read-dummy. A write to address 0 stores bits 7:0, and bits 31:8 read back 0.
- R3: Status bits 3:0 are idle, run, wait and pause, one-hot. If halt and pause are 0 and enable is 1, an idle or paused core is in run one clock after the control write takes effect. `core_run` is high exactly in run.
- R4: Halt outranks pause. With halt 0 and pause 1, a running core moves to pause on the next clock. With both set, it follows the halt rules of R5 and R6.
- R5: With halt 1 and halt mode 0, a running or paused core enters wait. It stays in wait until `wb_done` is sampled high, then goes to idle.
- R6: With halt mode 1, a halted core goes straight to idle, and so does a core in wait, on the next clock without `wb_done`.
- R7: Writing address 0 with bit 8 set gives exactly one `fifo_clr` pulse in the cycle after the write. Bit 8 is not stored and reads 0.
- R8: `byte_stb` counts bytes, including a strobe in the cycle of `eof_seen`. The count saturates at 16383. On `eof_seen` with no count held, the count is latched into status bits 29:16 and the running count restarts at 0.
- R9: An `eof_seen` while a count is held leaves the held count unchanged and sets status bit 30. The flag stays set until cleared. Writing address 2 with bit 31 set zeroes the held count, the running count and the flag. Bit 31 always reads 0.
- R10: Address 1 holds a 16-bit tail count, visible on `tail_bits`. Control bits 3 and 4 drive `tail_on_write` and `cond_ne`.
- R11: When the core goes from idle to run with fetch mode 0, `prefetch_req` pulses high for the first run cycle. With fetch mode 1 it stays low.
- R12: `in_req` is high in run. With read-dummy 1 it drops in the cycle after an `eof_seen`, and it stays low until the core returns to idle.
- R13: Status bit 4 reflects `fifo_empty` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 control, 1 tail, 2 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| wb_done | input | 1 | Datapath write-back finished |
| eof_seen | input | 1 | End of frame observed |
| byte_stb | input | 1 | One byte moved |
| fifo_empty | input | 1 | Datapath FIFO empty |
| core_run | output | 1 | Sequencer in run |
| in_req | output | 1 | Request input data |
| prefetch_req | output | 1 | Fetch first instruction |
| fifo_clr | output | 1 | One-cycle FIFO reset pulse |
| tail_bits | output | 16 | Extra bits to process after EOF |
| tail_on_write | output | 1 | Tail count advances on peripheral writes (1) or DMA reads (0) |
| cond_ne | output | 1 | Loop condition uses not-equal (1) or less-than (0) |

## Verification
A register write takes effect at the rising edge that samples it. The sequencer reacts one edge later, so a state change shows up on the second edge after the write. `prefetch_req`, `fifo_clr`, the read-dummy drop of `in_req`, and the latching of EOF counts and the overload flag all appear one edge after their cause. Reads and the FIFO-empty status bit follow their inputs within the same cycle. The reference model in the bench advances once per rising edge. Inputs change on falling edges, and the bench compares the outputs 2 ns after each rising edge, so every result is sampled in the cycle it is due. The directed checks wait a fixed number of cycles that follows from this delay count.

// File: rtl/scx_pkg.sv
`timescale 1ns/1ps
package scx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_PAUSE = 2'd3
  } scx_state_e;

  // Packed so that bit 0 is enable and bit 7 is read-dummy
  typedef struct packed {
    logic rd_dummy;
    logic halt_mode;
    logic fetch_mode;
    logic cond_mode;
    logic eof_mode;
    logic halt;
    logic pause;
    logic en;
  } scx_ctrl_t;

  localparam int CTRL_FIELDS   = 8;
  localparam int FIFO_CLR_BIT  = 8;
  localparam int EMPTY_BIT     = 4;
  localparam int CNT_LSB       = 16;
  localparam int OVF_BIT       = 30;
  localparam int TRACE_CLR_BIT = 31;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_TAIL = 1;
  localparam int ADDR_STAT = 2;

  localparam logic [CTRL_FIELDS-1:0] CTRL_RESET = 8'h04;

endpackage

// File: rtl/scx_regs.sv
`timescale 1ns/1ps
module scx_regs
  import scx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAIL_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output scx_ctrl_t         ctrl,
  output logic [TAIL_W-1:0] tail,
  output logic              fifo_clr,
  output logic              trace_clr
);

  logic wr_ctrl, wr_tail, wr_stat;
  scx_ctrl_t         ctrl_q, ctrl_d;
  logic [TAIL_W-1:0] tail_q, tail_d;
  logic              clr_q, clr_d;
  logic              wdata_unused;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(ADDR_CTRL));
  assign wr_tail = wr_en && (addr == ADDR_W'(ADDR_TAIL));
  assign wr_stat = wr_en && (addr == ADDR_W'(ADDR_STAT));
  assign wdata_unused = ^wdata[TRACE_CLR_BIT-1:TAIL_W];

  always_comb begin
    ctrl_d = ctrl_q;
    tail_d = tail_q;
    clr_d  = wr_ctrl && wdata[FIFO_CLR_BIT];
    if (wr_ctrl) ctrl_d = scx_ctrl_t'(wdata[CTRL_FIELDS-1:0]);
    if (wr_tail) tail_d = wdata[TAIL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= scx_ctrl_t'(CTRL_RESET);
      tail_q <= '0;
      clr_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      tail_q <= tail_d;
      clr_q  <= clr_d;
    end
  end

  assign ctrl      = ctrl_q;
  assign tail      = tail_q;
  assign fifo_clr  = clr_q;
  assign trace_clr = wr_stat && wdata[TRACE_CLR_BIT];

  // R7
  fifo_clr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> $past(wr_ctrl && wdata[FIFO_CLR_BIT]));

endmodule

// File: rtl/scx_fsm.sv
`timescale 1ns/1ps
module scx_fsm
  import scx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  scx_ctrl_t  ctrl,
  input  logic       wb_done,
  input  logic       eof_seen,
  output scx_state_e state,
  output logic       prefetch,
  output logic       in_req
);

  scx_state_e state_q, state_d;
  logic       pf_q, pf_d;
  logic       eof_got_q, eof_got_d;

  always_comb begin
    state_d = state_q;
    if (state_q == ST_WAIT) begin
      if (wb_done || ctrl.halt_mode) state_d = ST_IDLE;
    end else if (ctrl.halt) begin
      if (state_q != ST_IDLE) state_d = ctrl.halt_mode ? ST_IDLE : ST_WAIT;
    end else if (ctrl.pause) begin
      if (state_q == ST_RUN) state_d = ST_PAUSE;
    end else if (ctrl.en && (state_q == ST_IDLE || state_q == ST_PAUSE)) begin
      state_d = ST_RUN;
    end
  end

  always_comb begin
    pf_d      = (state_q == ST_IDLE) && (state_d == ST_RUN) && !ctrl.fetch_mode;
    eof_got_d = (state_q == ST_IDLE) ? 1'b0 : (eof_got_q || eof_seen);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pf_q      <= 1'b0;
      eof_got_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      pf_q      <= pf_d;
      eof_got_q <= eof_got_d;
    end
  end

  assign state    = state_q;
  assign prefetch = pf_q;
  assign in_req   = (state_q == ST_RUN) && !(ctrl.rd_dummy && eof_got_q);

  // R5
  wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && wb_done) |=> state_q == ST_IDLE);

  // R6
  abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.halt && ctrl.halt_mode) |=> state_q == ST_IDLE);

  // R4
  halt_over_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && ctrl.halt && ctrl.pause && !ctrl.halt_mode) |=> state_q == ST_WAIT);

  // R4
  pause_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !ctrl.halt && ctrl.pause) |=> state_q == ST_PAUSE);

  // R11
  prefetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_q |-> (state_q == ST_RUN && $past(state_q == ST_IDLE)));

endmodule

// File: rtl/scx_eof_trace.sv
`timescale 1ns/1ps
module scx_eof_trace #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             eof,
  input  logic             byte_stb,
  output logic [CNT_W-1:0] held_cnt,
  output logic             ovf
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] run_q, run_d, held_q, held_d, inc;
  logic             hv_q, hv_d, ovf_q, ovf_d;

  assign inc = (run_q == CNT_MAX) ? run_q : run_q + CNT_W'(byte_stb);

  always_comb begin
    run_d  = inc;
    held_d = held_q;
    hv_d   = hv_q;
    ovf_d  = ovf_q;
    if (clr) begin
      run_d  = '0;
      held_d = '0;
      hv_d   = 1'b0;
      ovf_d  = 1'b0;
    end else if (eof) begin
      run_d = '0;
      if (hv_q) begin
        ovf_d = 1'b1;
      end else begin
        held_d = inc;
        hv_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      held_q <= '0;
      hv_q   <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      held_q <= held_d;
      hv_q   <= hv_d;
      ovf_q  <= ovf_d;
    end
  end

  assign held_cnt = held_q;
  assign ovf      = ovf_q;

  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && hv_q && !clr) |=> (ovf_q && $stable(held_q)));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr) |=> ovf_q);

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == CNT_MAX && !clr && !eof) |=> run_q == CNT_MAX);

endmodule

// File: rtl/scx_run_ctrl.sv
`timescale 1ns/1ps
module scx_run_ctrl
  import scx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 2,
  parameter int TAIL_W      = 16,
  parameter int CNT_W       = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              wb_done,
  input  logic              eof_seen,
  input  logic              byte_stb,
  input  logic              fifo_empty,
  output logic              core_run,
  output logic              in_req,
  output logic              prefetch_req,
  output logic              fifo_clr,
  output logic [TAIL_W-1:0] tail_bits,
  output logic              tail_on_write,
  output logic              cond_ne
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q = rst_pipe[SYNC_STAGES-1];

  scx_ctrl_t        ctrl;
  scx_state_e       state;
  logic             trace_clr;
  logic [CNT_W-1:0] held_cnt;
  logic             ovf;
  logic [DATA_W-1:0] stat_word;

  scx_regs #(.DATA_W(DATA_W), .TAIL_W(TAIL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_q),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .ctrl     (ctrl),
    .tail     (tail_bits),
    .fifo_clr (fifo_clr),
    .trace_clr(trace_clr)
  );

  scx_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_q),
    .ctrl    (ctrl),
    .wb_done (wb_done),
    .eof_seen(eof_seen),
    .state   (state),
    .prefetch(prefetch_req),
    .in_req  (in_req)
  );

  scx_eof_trace #(.CNT_W(CNT_W)) u_trace (
    .clk     (clk),
    .rst_n   (rst_q),
    .clr     (trace_clr),
    .eof     (eof_seen),
    .byte_stb(byte_stb),
    .held_cnt(held_cnt),
    .ovf     (ovf)
  );

  always_comb begin
    stat_word                   = '0;
    stat_word[0]                = (state == ST_IDLE);
    stat_word[1]                = (state == ST_RUN);
    stat_word[2]                = (state == ST_WAIT);
    stat_word[3]                = (state == ST_PAUSE);
    stat_word[EMPTY_BIT]        = fifo_empty;
    stat_word[CNT_LSB +: CNT_W] = held_cnt;
    stat_word[OVF_BIT]          = ovf;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(ADDR_CTRL): reg_rdata[CTRL_FIELDS-1:0] = ctrl;
      ADDR_W'(ADDR_TAIL): reg_rdata[TAIL_W-1:0]      = tail_bits;
      ADDR_W'(ADDR_STAT): reg_rdata                  = stat_word;
      default:            reg_rdata                  = '0;
    endcase
  end

  assign core_run      = (state == ST_RUN);
  assign tail_on_write = ctrl.eof_mode;
  assign cond_ne       = ctrl.cond_mode;

  // R3
  state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot(stat_word[3:0]));

  // R12
  in_req_run_chk: assert property (@(posedge clk) disable iff (!rst_q)
    in_req |-> core_run);

endmodule

// File: tb/scx_run_ctrl_bench.sv
`timescale 1ns/1ps
module scx_run_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        wb_done = 1'b0, eof_seen = 1'b0, byte_stb = 1'b0, fifo_empty = 1'b0;
  logic        core_run, in_req, prefetch_req, fifo_clr, tail_on_write, cond_ne;
  logic [15:0] tail_bits;

  int checks = 0;
  int errors = 0;
  int pf_seen = 0;
  int clr_seen = 0;
  bit done = 0;

  always #4 clk = ~clk;

  scx_run_ctrl u_scx_run_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wb_done(wb_done),
    .eof_seen(eof_seen), .byte_stb(byte_stb), .fifo_empty(fifo_empty),
    .core_run(core_run), .in_req(in_req), .prefetch_req(prefetch_req),
    .fifo_clr(fifo_clr), .tail_bits(tail_bits), .tail_on_write(tail_on_write),
    .cond_ne(cond_ne)
  );

  // ---------------- behavioural reference ----------------
  bit [7:0]  m_ctrl;
  bit [15:0] m_tail;
  int        m_st;    // 0 idle 1 run 2 wait 3 pause
  int        m_run, m_held;
  bit        m_hv, m_ovf, m_eg, m_pf, m_fc;
  bit [1:0]  m_sync;

  task automatic m_reset();
    m_ctrl = 8'h04; m_tail = 0; m_st = 0; m_run = 0; m_held = 0;
    m_hv = 0; m_ovf = 0; m_eg = 0; m_pf = 0; m_fc = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 2'b00;
      m_reset();
    end else if (!m_sync[1]) begin
      m_reset();
      m_sync = {m_sync[0], 1'b1};
    end else begin
      int nst, inc;
      bit en, pa, ha, fm, hm;
      en = m_ctrl[0]; pa = m_ctrl[1]; ha = m_ctrl[2]; fm = m_ctrl[5]; hm = m_ctrl[6];
      nst = m_st;
      if (m_st == 2) begin
        if (wb_done || hm) nst = 0;
      end else if (ha) begin
        if (m_st != 0) nst = hm ? 0 : 2;
      end else if (pa) begin
        if (m_st == 1) nst = 3;
      end else if (en && (m_st == 0 || m_st == 3)) nst = 1;
      m_pf = (m_st == 0) && (nst == 1) && !fm;
      m_eg = (m_st == 0) ? 1'b0 : (m_eg || eof_seen);
      inc = m_run + (byte_stb ? 1 : 0);
      if (inc > 16383) inc = 16383;
      if (reg_wr && reg_addr == 2 && reg_wdata[31]) begin
        m_run = 0; m_held = 0; m_hv = 0; m_ovf = 0;
      end else if (eof_seen) begin
        m_run = 0;
        if (m_hv) m_ovf = 1;
        else begin m_held = inc; m_hv = 1; end
      end else m_run = inc;
      m_fc = reg_wr && reg_addr == 0 && reg_wdata[8];
      if (reg_wr && reg_addr == 0) m_ctrl = reg_wdata[7:0];
      if (reg_wr && reg_addr == 1) m_tail = reg_wdata[15:0];
      m_st = nst;
    end
  end

  function automatic [31:0] m_read(input [1:0] a);
    case (a)
      2'd0: m_read = {24'd0, m_ctrl};
      2'd1: m_read = {16'd0, m_tail};
      2'd2: m_read = {1'b0, m_ovf, m_held[13:0], 11'd0, fifo_empty,
                      m_st == 3, m_st == 2, m_st == 1, m_st == 0};
      default: m_read = 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input [31:0] act, input [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual 0x%08h expected 0x%08h", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison, 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      logic [31:0] e;
      e = m_read(reg_addr);
      if (reg_addr == 2) begin
        check("R3 state flags", {28'd0, reg_rdata[3:0]}, {28'd0, e[3:0]});
        check("R13 fifo empty", {31'd0, reg_rdata[4]}, {31'd0, e[4]});
        check("R8 eof count", {18'd0, reg_rdata[29:16]}, {18'd0, e[29:16]});
        check("R9 overload", {31'd0, reg_rdata[30]}, {31'd0, e[30]});
      end else if (reg_addr == 1) check("R10 tail read", reg_rdata, e);
      else check("R2 read", reg_rdata, e);
      check("R3 core_run", {31'd0, core_run}, {31'd0, m_st == 1});
      check("R12 in_req", {31'd0, in_req}, {31'd0, (m_st == 1) && !(m_ctrl[7] && m_eg)});
      check("R11 prefetch", {31'd0, prefetch_req}, {31'd0, m_pf});
      check("R7 fifo_clr", {31'd0, fifo_clr}, {31'd0, m_fc});
      check("R10 tail outputs", {14'd0, cond_ne, tail_on_write, tail_bits},
            {14'd0, m_ctrl[4], m_ctrl[3], m_tail});
      if (prefetch_req) pf_seen++;
      if (fifo_clr) clr_seen++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input [1:0] a, input [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 32'd0;
  endtask

  task automatic peek(input [1:0] a, output [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R1 reset values
    peek(0, v); check("R1 ctrl reset", v, 32'h4);
    peek(2, v); check("R1 status reset", v, 32'h1);
    peek(1, v); check("R1 tail reset", v, 32'h0);

    // R10 tail and mode bits
    wreg(1, 32'hFFFF_A5C3);
    wreg(0, 32'h0000_001C);
    cyc(1);
    peek(1, v); check("R10 tail", v, 32'h0000_A5C3);
    check("R10 modes", {30'd0, cond_ne, tail_on_write}, 32'h3);

    // R3/R11 run from idle with prefetch
    pf_seen = 0;
    wreg(0, 32'h1);
    cyc(3);
    peek(2, v); check("R3 run", v & 32'hF, 32'h2);
    check("R11 one prefetch", pf_seen, 1);

    // R8 count: five strobes then a strobe with EOF
    byte_stb = 1; cyc(5);
    eof_seen = 1; cyc(1);
    byte_stb = 0; eof_seen = 0; cyc(1);
    peek(2, v); check("R8 held count", {18'd0, v[29:16]}, 32'd6);
    eof_seen = 1; cyc(1); eof_seen = 0; cyc(1);
    peek(2, v); check("R9 overload set", {v[30], v[29:16]}, {1'b1, 14'd6});
    wreg(2, 32'h8000_0000);
    cyc(1);
    peek(2, v); check("R9 clear", v & 32'hFFFF_0000, 32'h0);

    // R4 pause, then halt over pause, R5 wait
    wreg(0, 32'h3); cyc(2);
    peek(2, v); check("R4 paused", v & 32'hF, 32'h8);
    wreg(0, 32'h1); cyc(2);
    wreg(0, 32'h7); cyc(4);
    peek(2, v); check("R4 halt wins to wait", v & 32'hF, 32'h4);
    wb_done = 1; cyc(1); wb_done = 0; cyc(1);
    peek(2, v); check("R5 idle after wb", v & 32'hF, 32'h1);

    // R6 abandon write-back
    wreg(0, 32'h1); cyc(2);
    wreg(0, 32'h45); cyc(2);
    peek(2, v); check("R6 idle at once", v & 32'hF, 32'h1);

    // R11 fetch mode 1
    pf_seen = 0;
    wreg(0, 32'h21); cyc(3);
    check("R11 no prefetch", pf_seen, 0);
    check("R3 running", {31'd0, core_run}, 32'd1);

    // R12 read-dummy
    wreg(0, 32'h44); cyc(2);
    wreg(0, 32'hA1); cyc(3);
    check("R12 req before eof", {31'd0, in_req}, 32'd1);
    eof_seen = 1; cyc(1); eof_seen = 0; cyc(1);
    check("R12 req after eof", {31'd0, in_req}, 32'd0);

    // R7 fifo reset pulse
    clr_seen = 0;
    wreg(0, 32'h1A1); cyc(3);
    check("R7 one pulse", clr_seen, 1);
    peek(0, v); check("R7 bit8 reads 0", v, 32'hA1);

    // R13 fifo empty
    fifo_empty = 1; peek(2, v); check("R13 empty", {31'd0, v[4]}, 32'd1);
    fifo_empty = 0;

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      byte_stb   = $urandom() % 2;
      eof_seen   = ($urandom() % 16) == 0;
      wb_done    = ($urandom() % 4) == 0;
      fifo_empty = $urandom() % 2;
      reg_addr   = $urandom() % 4;
      reg_wr     = ($urandom() % 8) == 0;
      reg_wdata  = $urandom();
    end
    @(negedge clk);
    reg_wr = 0; byte_stb = 0; eof_seen = 0; wb_done = 0;

    // R8 saturation
    wreg(2, 32'h8000_0000);
    byte_stb = 1; cyc(16500);
    eof_seen = 1; cyc(1);
    eof_seen = 0; byte_stb = 0; cyc(1);
    peek(2, v); check("R8 saturate", {18'd0, v[29:16]}, 32'd16383);

    cyc(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule